// File: doc/BRIEF.md
# Integer Execute Unit with Operand Extension

This block is the integer arithmetic and logic stage of a 32-bit load/store RISC pipeline. Each cycle it takes two register operands, a 16-bit immediate, a 4-bit operation code and a flag that selects the immediate in place of the second register operand. On the next rising clock edge it presents a 32-bit result and a signed-overflow flag.

How the immediate is widened depends on the operation. Arithmetic and compare operations sign-extend it. This includes the unsigned add and the unsigned compare, which still compares as magnitudes after the sign extension. The bitwise operations fill the upper half with zeros. Add, subtract and both compares share one modulo-2^32 adder. Subtraction is done by inverting the second operand and feeding a carry-in of one.

Overflow is reported only for the signed add and signed subtract. The exception logic that acts on it lives elsewhere.

Top module: `alu_exec_unit`

## Requirements
- R1: Outputs are registered with a latency of one clock. A synchronous active-high `rst` clears `result_q` to 0 and `ovf_q` to 0.
- R2: Codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) give A+B or A-B modulo 2^32. A is `rs_val` and B is the second operand.
- R3: For codes 0 and 2, `ovf_q` is 1 exactly when the true signed result does not fit in 32 bits. For code 0 this is when both operands share a sign and the sum sign differs. For code 2 it is the same test applied to A and the inverted B.
- R4: Every code other than 0 and 2 leaves `ovf_q` at 0. This includes codes 1 and 3 when they wrap.
- R5: Code 4 writes 1 when A is less than B as two's complement numbers, and 0 otherwise. Bits 31..1 of the result are zero.
- R6: Code 5 writes 1 when A is less than B as unsigned magnitudes, and 0 otherwise. With `imm_sel`=1, B is the sign-extended immediate.
- R7: With `imm_sel`=1, codes 0 to 5 use the immediate sign-extended from bit 15 to 32 bits as B.
- R8: With `imm_sel`=0, codes 6, 7, 8 and 9 give A AND B, A OR B, A XOR B and NOR of A and B respectively.
- R9: With `imm_sel`=1, codes 6, 7 and 8 use the immediate zero-extended to 32 bits as B.
- R10: Codes 10 to 15, and code 9 with `imm_sel`=1, give a result of 0 with `ovf_q` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| imm_sel | input | 1 | 1: second operand is the extended immediate |
| rs_val | input | 32 | First register operand (A) |
| rt_val | input | 32 | Second register operand |
| imm_val | input | 16 | Immediate field |
| result_q | output | 32 | Registered result |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
The hardest cases to reach are at the edges of the signed range. Overflow must show on both boundaries and for both add and subtract. The unsigned twins must stay silent on the very same operand pairs. The bench therefore drives directed pairs such as 0x7FFFFFFF+1, 0x80000000+0x80000000 and 0x80000000-1 through both the signed and unsigned codes back to back. A second hard case is the unsigned compare against an immediate of 0xFFFF, whose sign extension becomes the largest 32-bit magnitude. The bench drives directed immediates for this and then a run of random operands, and compares every cycle against a model written from the requirements.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_SLT  = 4'd4,
    OP_SLTU = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOR  = 4'd9
  } alu_op_e;

  function automatic logic zero_ext_op(input logic [OP_W-1:0] code);
    return (code == OP_AND) || (code == OP_OR) || (code == OP_XOR);
  endfunction

  function automatic logic subtract_op(input logic [OP_W-1:0] code);
    return (code == OP_SUB) || (code == OP_SUBU) ||
           (code == OP_SLT) || (code == OP_SLTU);
  endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              zero_fill,
  output logic [DATA_W-1:0] wide
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill_bit;

  // Upper bits are either copies of the immediate's top bit or zeros
  assign fill_bit = zero_fill ? 1'b0 : imm[IMM_W-1];
  assign wide     = {{PAD_W{fill_bit}}, imm};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              sgn_ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  // Subtraction: add the bitwise inverse of b with a carry-in of one
  assign b_eff   = sub ? ~b : b;
  assign full    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum     = full[DATA_W-1:0];
  assign carry   = full[DATA_W];
  assign sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        fn,
  output logic [DATA_W-1:0] y
);
  // fn: 0 and, 1 or, 2 xor, 3 nor
  always_comb begin
    unique case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_code,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] result_q,
  output logic              ovf_q
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] imm_wide;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_sum;
  logic              arith_carry;
  logic              arith_ovf;
  logic [DATA_W-1:0] bit_res;
  logic [1:0]        bit_fn;
  logic [DATA_W-1:0] res_d;
  logic              ovf_d;

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) ext_i (
    .imm       (imm_val),
    .zero_fill (zero_ext_op(op_code)),
    .wide      (imm_wide)
  );

  assign opnd_b = imm_sel ? imm_wide : rt_val;

  alu_addsub #(.DATA_W(DATA_W)) add_i (
    .a       (rs_val),
    .b       (opnd_b),
    .sub     (subtract_op(op_code)),
    .sum     (arith_sum),
    .carry   (arith_carry),
    .sgn_ovf (arith_ovf)
  );

  // Bitwise function index relative to the first logical code
  assign bit_fn = 2'(op_code - 4'(OP_AND));

  alu_bitwise #(.DATA_W(DATA_W)) bw_i (
    .a  (rs_val),
    .b  (opnd_b),
    .fn (bit_fn),
    .y  (bit_res)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    case (op_code)
      OP_ADD, OP_SUB: begin
        res_d = arith_sum;
        ovf_d = arith_ovf;
      end
      OP_ADDU, OP_SUBU: res_d = arith_sum;
      // Signed less-than: sign of the difference corrected by overflow
      OP_SLT:  res_d = {{MSB{1'b0}}, arith_sum[MSB] ^ arith_ovf};
      // Unsigned less-than: a borrow (no carry out) from a - b
      OP_SLTU: res_d = {{MSB{1'b0}}, ~arith_carry};
      OP_AND, OP_OR, OP_XOR: res_d = bit_res;
      OP_NOR:  res_d = imm_sel ? '0 : bit_res;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      result_q <= res_d;
      ovf_q    <= ovf_d;
    end
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_code,
  input logic              imm_sel,
  input logic [DATA_W-1:0] rs_val,
  input logic [IMM_W-1:0]  imm_val,
  input logic [DATA_W-1:0] result_q,
  input logic              ovf_q
);
  localparam int MSB = DATA_W - 1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result_q == '0) && !ovf_q);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) != 4'd0 && $past(op_code) != 4'd2) |-> !ovf_q);

  // R3
  ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf_q) |-> (result_q[MSB] != $past(rs_val[MSB])));

  // R5
  slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == 4'd4 || $past(op_code) == 4'd5))
      |-> (result_q[DATA_W-1:1] == '0));

  // R9
  andi_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(imm_sel) && $past(op_code) == 4'd6)
      |-> (result_q[DATA_W-1:IMM_W] == '0) && (result_q[IMM_W-1:0] == ($past(rs_val[IMM_W-1:0]) & $past(imm_val))));

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) >= 4'd10 || ($past(op_code) == 4'd9 && $past(imm_sel))))
      |-> (result_q == '0) && !ovf_q);
endmodule

bind alu_exec_unit alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_code  (op_code),
  .imm_sel  (imm_sel),
  .rs_val   (rs_val),
  .imm_val  (imm_val),
  .result_q (result_q),
  .ovf_q    (ovf_q)
);

// File: tb/alu_exec_unit_tb_top.sv
`timescale 1ns/1ps
module alu_exec_unit_tb_top;
  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [15:0] imm_val = '0;
  logic [31:0] result_q;
  logic        ovf_q;

  int checks = 0;
  int errors = 0;
  exp_t sb_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_exec_unit dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .imm_sel(imm_sel),
    .rs_val(rs_val), .rt_val(rt_val), .imm_val(imm_val),
    .result_q(result_q), .ovf_q(ovf_q)
  );

  function automatic exp_t model(input logic [3:0] op, input logic isel,
                                 input logic [31:0] a, input logic [31:0] r,
                                 input logic [15:0] im, input string tag);
    exp_t e;
    logic [31:0] b;
    longint sa, sb, st;
    e.res = '0; e.ovf = 1'b0; e.tag = tag;
    if (isel) b = (op >= 4'd6 && op <= 4'd8) ? {16'h0, im} : {{16{im[15]}}, im};
    else      b = r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      4'd0: begin e.res = a + b; st = sa + sb; e.ovf = (st > 64'sd2147483647) || (st < -64'sd2147483648); end
      4'd1: e.res = a + b;
      4'd2: begin e.res = a - b; st = sa - sb; e.ovf = (st > 64'sd2147483647) || (st < -64'sd2147483648); end
      4'd3: e.res = a - b;
      4'd4: e.res = (sa < sb) ? 32'd1 : 32'd0;
      4'd5: e.res = (a < b) ? 32'd1 : 32'd0;
      4'd6: e.res = a & b;
      4'd7: e.res = a | b;
      4'd8: e.res = a ^ b;
      4'd9: e.res = isel ? 32'd0 : ~(a | b);
      default: e.res = '0;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic isel, input logic [31:0] a,
                       input logic [31:0] r, input logic [15:0] im, input string tag);
    @(negedge clk);
    op_code = op; imm_sel = isel; rs_val = a; rt_val = r; imm_val = im;
    sb_q.push_back(model(op, isel, a, r, im, tag));
  endtask

  // Monitor: each result appears one clock after the inputs were applied
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (result_q !== e.res || ovf_q !== e.ovf) begin
          errors++;
          $display("FAIL %s: got res=%h ovf=%b expected res=%h ovf=%b",
                   e.tag, result_q, ovf_q, e.res, e.ovf);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with busy inputs present
    op_code = 4'd0; rs_val = 32'h7fffffff; rt_val = 32'h1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result_q !== 32'h0 || ovf_q !== 1'b0) begin
      errors++;
      $display("FAIL R1: got res=%h ovf=%b expected res=0 ovf=0", result_q, ovf_q);
    end
    @(negedge clk);
    rst = 1'b0;
    // R1/R2 basic add
    drive(4'd0, 0, 32'd15, 32'd7, 16'h0, "R1_R2 add");
    // R3 signed overflow positive and negative
    drive(4'd0, 0, 32'h7fffffff, 32'd1, 16'h0, "R3 add pos ovf");
    drive(4'd0, 0, 32'h80000000, 32'h80000000, 16'h0, "R3 add neg ovf");
    drive(4'd2, 0, 32'h80000000, 32'd1, 16'h0, "R3 sub ovf");
    drive(4'd2, 0, 32'd0, 32'h80000000, 16'h0, "R3 sub ovf zero minus min");
    drive(4'd2, 0, 32'd5, 32'd9, 16'h0, "R2 sub no ovf");
    // R4 unsigned twins stay silent
    drive(4'd1, 0, 32'h7fffffff, 32'd1, 16'h0, "R4 addu wrap");
    drive(4'd3, 0, 32'h80000000, 32'd1, 16'h0, "R4 subu wrap");
    drive(4'd1, 0, 32'hffffffff, 32'd2, 16'h0, "R2 addu modulo");
    // R5 signed compare
    drive(4'd4, 0, 32'hfffffffe, 32'd3, 16'h0, "R5 slt neg<pos");
    drive(4'd4, 0, 32'd3, 32'hfffffffe, 16'h0, "R5 slt pos<neg");
    drive(4'd4, 0, 32'h7fffffff, 32'h80000000, 16'h0, "R5 slt extremes");
    // R6 unsigned compare
    drive(4'd5, 0, 32'hfffffffe, 32'd3, 16'h0, "R6 sltu big");
    drive(4'd5, 1, 32'd5, 32'd0, 16'hffff, "R6 sltu imm sext");
    drive(4'd5, 1, 32'hffffffff, 32'd0, 16'hffff, "R6 sltu imm equal");
    // R7 arithmetic immediates sign-extended
    drive(4'd1, 1, 32'd100, 32'd0, 16'hfff6, "R7 addiu neg imm");
    drive(4'd0, 1, 32'h80000000, 32'd0, 16'h8000, "R7 addi ovf");
    drive(4'd4, 1, 32'hffffff00, 32'd0, 16'hff80, "R7 slti");
    // R8 register logic
    drive(4'd6, 0, 32'hf0f0a5a5, 32'h0ff0ffff, 16'h0, "R8 and");
    drive(4'd7, 0, 32'hf0f00000, 32'h000f0f0f, 16'h0, "R8 or");
    drive(4'd8, 0, 32'haaaa5555, 32'hffff0000, 16'h0, "R8 xor");
    drive(4'd9, 0, 32'h0000ffff, 32'h00ff0000, 16'h0, "R8 nor");
    // R9 logic immediates zero-extended
    drive(4'd7, 1, 32'h00000000, 32'hffffffff, 16'h8000, "R9 ori");
    drive(4'd6, 1, 32'hffffffff, 32'd0, 16'h8001, "R9 andi");
    drive(4'd8, 1, 32'h12345678, 32'd0, 16'hffff, "R9 xori");
    // R10 unused codes
    drive(4'd9, 1, 32'h0, 32'h0, 16'h0, "R10 nor imm");
    for (int c = 10; c < 16; c++)
      drive(4'(c), 0, 32'hffffffff, 32'h7fffffff, 16'hffff, "R10 unused code");
    // Random sweep across all codes
    for (int i = 0; i < 400; i++)
      drive(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), $urandom, $urandom,
            16'($urandom), "R2_R9 random");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule